// File: doc/BRIEF.md
# Core Idle-State Controller

This block decides when a four-thread processor core may stop and how deeply. Each hardware thread reports the power-save instruction it has executed, asking for either a light idle state (Nap) or a deep one (Sleep). The core stays running until every thread has made such a request. It then goes to Nap if any thread asked for Nap, and to Sleep only if all of them asked for Sleep. In Nap the execution units and L1 lose their clocks while the upper caches and timers keep running. A mode bit can also ask for a lower cache frequency during Nap. Before the core region loses all of its clocks, Sleep first runs a cache purge handshake.

An always-on wake section latches external and timer interrupts while the core is idle. The next cycle it returns the core to running, in a way that looks like a thread-level reset. Firmware can hold a maintenance override that brings the clocks back to an idle core for register access. While the override is held, instruction execution stays stopped and any wakeup waits. An all-sleeping status lets a chip-level controller combine the cores and drop the supply to retention level.

All pins are plain control and status levels or single-cycle pulses. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `core_idle_ctrl`

## Requirements
- R1: A power-save request from a thread is recorded only while the core is running (idle_state 0). It stays recorded, with its kind (ps_kind 1 = Sleep, 0 = Nap), until the next exit from an idle state. A request raised while idle is ignored.
- R2: The core leaves running only when all threads hold a recorded request. idle_state changes on the clock edge after the edge that records the last request.
- R3: If any recorded request is Nap, the core enters Nap (idle_state 1).
- R4: If every recorded request is Sleep, the core first enters the purge phase (idle_state 2) with purge_req high. On the edge after purge_done is seen high, it moves to Sleep (idle_state 3). purge_req is low in every other state.
- R5: exec_clk_en is high only while running or under maintenance. region_clk_en is low only in Sleep without maintenance.
- R6: freq_drop_req takes the value of nap_fdrop_mode at Nap entry and holds it for the whole Nap. It is low outside Nap.
- R7: While the core is idle (idle_state 1, 2 or 3), a high ext_irq or timer_irq at a clock edge latches a wake. From Nap or Sleep, a latched wake with no maintenance returns idle_state to 0 on the next edge, and run_en rises at once. If the frequency had been dropped in Nap, freq_slew_up pulses for exactly that first running cycle.
- R8: In the first running cycle after an exit, thread_rst is high for all threads for one cycle, and all recorded requests are cleared.
- R9: While fw_maint is high, an idle core has exec_clk_en and region_clk_en high, run_en stays low, and no exit happens. A latched wake is kept until fw_maint falls.
- R10: all_sleep is high exactly in Sleep without maintenance.
- R11: During and right after reset the core is running with no recorded requests: run_en, exec_clk_en and region_clk_en are high, and every other output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps_valid | input | 4 | Per-thread power-save instruction strobe |
| ps_kind | input | 4 | Per-thread request kind, 1 = Sleep, 0 = Nap |
| nap_fdrop_mode | input | 1 | Request a lower cache frequency while in Nap |
| ext_irq | input | 1 | External interrupt level |
| timer_irq | input | 1 | Timer interrupt level |
| purge_done | input | 1 | Cache purge finished |
| fw_maint | input | 1 | Firmware maintenance override |
| idle_state | output | 2 | 0 run, 1 nap, 2 purge, 3 sleep |
| run_en | output | 1 | Instruction execution allowed |
| exec_clk_en | output | 1 | Execution unit and L1 clock enable |
| region_clk_en | output | 1 | Whole core-region clock enable |
| purge_req | output | 1 | Cache purge request |
| freq_drop_req | output | 1 | Lower cache frequency request |
| freq_slew_up | output | 1 | One-cycle request to slew the frequency back up |
| thread_rst | output | 4 | Per-thread reset-vector pulse |
| all_sleep | output | 1 | Core is in Sleep at retention-eligible state |

## Verification
The bench aims at a wake that arrives during the purge phase. A design that drops the wake would never leave Sleep, and one that leaves too early would skip the purge. It holds maintenance across an interrupt: a faulty design would restart execution during register access or lose the wake when the override falls. It mixes Nap and Sleep requests and issues requests while the core is idle. This exposes a design that chooses Sleep when any thread wants it, or one that counts stale requests toward the next entry. It also toggles the frequency-drop mode during Nap, which catches a design that reads the live mode bit instead of the value latched at entry or that forgets the slew-up pulse.

// File: rtl/idle_pkg.sv
package idle_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_NAP   = 2'd1,
    ST_PURGE = 2'd2,
    ST_SLEEP = 2'd3
  } idle_st_e;
endpackage

// File: rtl/idle_thread_track.sv
module idle_thread_track #(
  parameter int NT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          clear,
  input  logic [NT-1:0] ps_valid,
  input  logic [NT-1:0] ps_kind,
  output logic          all_req,
  output logic          any_nap
);
  logic [NT-1:0] pend_q;
  logic [NT-1:0] sleep_q;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[t]  <= 1'b0;
        sleep_q[t] <= 1'b0;
      end else if (clear) begin
        pend_q[t]  <= 1'b0;
        sleep_q[t] <= 1'b0;
      end else if (accept && ps_valid[t]) begin
        pend_q[t]  <= 1'b1;
        sleep_q[t] <= ps_kind[t];
      end
    end
  end

  assign all_req = &pend_q;
  assign any_nap = |(pend_q & ~sleep_q);

  // R1
  ignore_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clear) |=> $stable(pend_q));
  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pend_q == '0));
endmodule

// File: rtl/idle_wake_sense.sv
module idle_wake_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic clear,
  input  logic ext_irq,
  input  logic timer_irq,
  output logic wake_pend
);
  logic hit;
  assign hit = ext_irq | timer_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wake_pend <= 1'b0;
    else if (clear)      wake_pend <= 1'b0;
    else if (!idle)      wake_pend <= 1'b0;
    else if (hit)        wake_pend <= 1'b1;
  end

  // R7
  wake_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && hit && !clear) |=> wake_pend);
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
  import idle_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     all_req,
  input  logic     any_nap,
  input  logic     wake_pend,
  input  logic     purge_done,
  input  logic     fw_maint,
  input  logic     drop_mode,
  output idle_st_e state,
  output logic     exit_now,
  output logic     drop_q,
  output logic     rst_pulse,
  output logic     slew_pulse
);
  idle_st_e state_n;

  assign exit_now = (state == ST_NAP || state == ST_SLEEP) && wake_pend && !fw_maint;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_RUN:   if (all_req) state_n = any_nap ? ST_NAP : ST_PURGE;
      ST_NAP:   if (exit_now) state_n = ST_RUN;
      ST_PURGE: if (purge_done) state_n = ST_SLEEP;
      ST_SLEEP: if (exit_now) state_n = ST_RUN;
      default:  state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      drop_q     <= 1'b0;
      rst_pulse  <= 1'b0;
      slew_pulse <= 1'b0;
    end else begin
      state      <= state_n;
      rst_pulse  <= exit_now;
      slew_pulse <= exit_now && (state == ST_NAP) && drop_q;
      if (state == ST_RUN && state_n == ST_NAP) drop_q <= drop_mode;
      else if (exit_now)                        drop_q <= 1'b0;
    end
  end

  // R2
  entry_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !all_req) |=> (state == ST_RUN));
  // R3
  nap_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && all_req && any_nap) |=> (state == ST_NAP));
  // R4
  sleep_via_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && $past(state) != ST_SLEEP) |-> ($past(state) == ST_PURGE));
  // R9
  maint_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_maint && state != ST_RUN) |=> (state != ST_RUN));
  // R8
  rst_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (state == ST_RUN));
endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl
  import idle_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] ps_valid,
  input  logic [NT-1:0] ps_kind,
  input  logic          nap_fdrop_mode,
  input  logic          ext_irq,
  input  logic          timer_irq,
  input  logic          purge_done,
  input  logic          fw_maint,
  output logic [1:0]    idle_state,
  output logic          run_en,
  output logic          exec_clk_en,
  output logic          region_clk_en,
  output logic          purge_req,
  output logic          freq_drop_req,
  output logic          freq_slew_up,
  output logic [NT-1:0] thread_rst,
  output logic          all_sleep
);
  idle_st_e st;
  logic all_req, any_nap, wake_pend, exit_now, drop_q, rst_pulse, slew_pulse;
  logic running;

  assign running = (st == ST_RUN);

  idle_thread_track #(.NT(NT)) u_track (
    .clk(clk), .rst_n(rst_n), .accept(running), .clear(exit_now),
    .ps_valid(ps_valid), .ps_kind(ps_kind),
    .all_req(all_req), .any_nap(any_nap)
  );

  idle_wake_sense u_wake (
    .clk(clk), .rst_n(rst_n), .idle(!running), .clear(exit_now),
    .ext_irq(ext_irq), .timer_irq(timer_irq), .wake_pend(wake_pend)
  );

  idle_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .all_req(all_req), .any_nap(any_nap),
    .wake_pend(wake_pend), .purge_done(purge_done), .fw_maint(fw_maint),
    .drop_mode(nap_fdrop_mode), .state(st), .exit_now(exit_now),
    .drop_q(drop_q), .rst_pulse(rst_pulse), .slew_pulse(slew_pulse)
  );

  assign idle_state    = st;
  assign run_en        = running;
  assign exec_clk_en   = running || fw_maint;
  assign region_clk_en = (st != ST_SLEEP) || fw_maint;
  assign purge_req     = (st == ST_PURGE);
  assign freq_drop_req = drop_q;
  assign freq_slew_up  = slew_pulse;
  assign thread_rst    = {NT{rst_pulse}};
  assign all_sleep     = (st == ST_SLEEP) && !fw_maint;

  // R10
  sleep_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_sleep |-> !region_clk_en);
  // R6
  drop_only_nap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_drop_req |-> (idle_state == 2'd1));
  // R7
  slew_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_slew_up |-> (run_en && thread_rst != '0));
endmodule

// File: tb/test_core_idle_ctrl.sv
module test_core_idle_ctrl;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] ps_valid = '0, ps_kind = '0;
  logic nap_fdrop_mode = 1'b0, ext_irq = 1'b0, timer_irq = 1'b0;
  logic purge_done = 1'b0, fw_maint = 1'b0;
  logic [1:0] idle_state;
  logic run_en, exec_clk_en, region_clk_en, purge_req, freq_drop_req, freq_slew_up, all_sleep;
  logic [NT-1:0] thread_rst;

  int n_run = 0, n_fail = 0, cyc = 0;

  // reference model state
  int m_st = 0;
  logic [NT-1:0] m_pend = '0, m_kind = '0;
  logic m_drop = 0, m_wake = 0, m_rst = 0, m_slew = 0;

  always #5 clk = ~clk;

  core_idle_ctrl #(.NT(NT)) i_core_idle_ctrl (
    .clk(clk), .rst_n(rst_n), .ps_valid(ps_valid), .ps_kind(ps_kind),
    .nap_fdrop_mode(nap_fdrop_mode), .ext_irq(ext_irq), .timer_irq(timer_irq),
    .purge_done(purge_done), .fw_maint(fw_maint), .idle_state(idle_state),
    .run_en(run_en), .exec_clk_en(exec_clk_en), .region_clk_en(region_clk_en),
    .purge_req(purge_req), .freq_drop_req(freq_drop_req), .freq_slew_up(freq_slew_up),
    .thread_rst(thread_rst), .all_sleep(all_sleep)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit exp_nap_any(input logic [NT-1:0] p, input logic [NT-1:0] k);
    return |(p & ~k);
  endfunction

  task automatic model_tick();
    bit idle, ex;
    int nst;
    idle = (m_st != 0);
    ex = (m_st == 1 || m_st == 3) && m_wake && !fw_maint;
    nst = m_st;
    case (m_st)
      0: if (&m_pend) nst = exp_nap_any(m_pend, m_kind) ? 1 : 2;
      1: if (ex) nst = 0;
      2: if (purge_done) nst = 3;
      3: if (ex) nst = 0;
      default: nst = 0;
    endcase
    m_slew = ex && (m_st == 1) && m_drop;
    m_rst  = ex;
    if (m_st == 0 && nst == 1) m_drop = nap_fdrop_mode;
    else if (ex) m_drop = 0;
    if (ex || !idle) m_wake = 0;
    else if (ext_irq || timer_irq) m_wake = 1;
    if (ex) begin m_pend = '0; m_kind = '0; end
    else if (m_st == 0) begin
      for (int t = 0; t < NT; t++) if (ps_valid[t]) begin m_pend[t] = 1; m_kind[t] = ps_kind[t]; end
    end
    m_st = nst;
  endtask

  task automatic check_all();
    bit mt;
    mt = fw_maint;
    chk("R2/R3/R4", "idle_state", idle_state, m_st);
    chk("R7", "run_en", run_en, m_st == 0);
    chk(mt ? "R9" : "R5", "exec_clk_en", exec_clk_en, (m_st == 0) || mt);
    chk(mt ? "R9" : "R5", "region_clk_en", region_clk_en, (m_st != 3) || mt);
    chk("R4", "purge_req", purge_req, m_st == 2);
    chk("R6", "freq_drop_req", freq_drop_req, m_drop);
    chk("R7", "freq_slew_up", freq_slew_up, m_slew);
    chk("R8", "thread_rst", thread_rst, m_rst ? 4'hF : 4'h0);
    chk("R10", "all_sleep", all_sleep, (m_st == 3) && !mt);
  endtask

  // inputs set before the call are sampled at the next edge
  task automatic step();
    @(posedge clk);
    cyc++;
    #1 model_tick();
    #2 check_all();
    ps_valid = '0;
    ext_irq = 0; timer_irq = 0; purge_done = 0;
  endtask

  task automatic req_all(input logic [NT-1:0] kinds);
    ps_valid = '1; ps_kind = kinds; step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1d1e5eed));
    repeat (3) @(posedge clk);
    #3;
    // R11 reset state
    chk("R11", "idle_state", idle_state, 0);
    chk("R11", "run_en", run_en, 1);
    chk("R11", "exec_clk_en", exec_clk_en, 1);
    chk("R11", "region_clk_en", region_clk_en, 1);
    chk("R11", "other outputs", {purge_req, freq_drop_req, freq_slew_up, thread_rst, all_sleep}, 0);
    rst_n = 1;
    step();

    // R2: three of four threads do not leave run
    ps_valid = 4'b0111; ps_kind = 4'b0000; step();
    step(); step();
    chk("R2", "still running", idle_state, 0);
    // R3: last thread asks Sleep, others Nap -> Nap with drop mode
    nap_fdrop_mode = 1; ps_valid = 4'b1000; ps_kind = 4'b1000; step();
    step();
    chk("R3", "nap chosen", idle_state, 1);
    nap_fdrop_mode = 0; step();
    chk("R6", "drop latched", freq_drop_req, 1);
    // R1: requests while idle are ignored
    ps_valid = '1; ps_kind = '1; step();
    ext_irq = 1; step(); step();
    chk("R7", "slew pulse", freq_slew_up, 1);
    chk("R8", "thread reset", thread_rst, 4'hF);
    step(); step();
    chk("R1", "ignored idle requests", idle_state, 0);

    // R4 + wake during purge + R9 maintenance in sleep
    req_all(4'hF); step();
    chk("R4", "purging", purge_req, 1);
    timer_irq = 1; step(); step();
    fw_maint = 1;
    purge_done = 1; step(); step(); step();
    chk("R9", "maint holds sleep", idle_state, 3);
    chk("R9", "no execution", run_en, 0);
    fw_maint = 0; step(); step();
    chk("R7", "exit after maint", idle_state, 0);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      ps_valid = ($urandom_range(0, 3) == 0) ? NT'($urandom) : '0;
      ps_kind = ($urandom_range(0, 1) == 0) ? '1 : NT'($urandom);
      ext_irq = (r < 4);
      timer_irq = (r >= 96);
      purge_done = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 29) == 0) fw_maint = ~fw_maint;
      if ($urandom_range(0, 19) == 0) nap_fdrop_mode = ~nap_fdrop_mode;
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule